// File: doc/BRIEF.md
# DRAM Address Remap Decoder

This block sits between the host address path and the DRAM ranks. It turns a host physical address into a rank index and a rank-relative DRAM address. It also recovers the DRAM that the PCI memory-mapped hole below 4 GiB would otherwise hide. When remapping is on, the host addresses from the top of low memory up to 4 GiB go to the PCI/MMIO path. The same DRAM is then reachable through a programmable window above 4 GiB, at a granularity of 64 MiB.

Software programs the block through a simple register write port. The registers hold the control word (enable, window base, window limit), the top-of-low-memory value, the top of RAM, and a start and end boundary for each rank. The top of RAM is also driven out as a byte address. Each request enters on a valid/ready handshake. Exactly one register stage later the block returns a region code (DRAM, remapped DRAM, PCI hole, or miss), the rank index and the translated address.

Top module: `dram_remap_decoder`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1, remapping is disabled, and `top_of_ram` is 0.
- R2: A write to register 2 loads bits [10:0] as the top of RAM in 16 MiB units. `top_of_ram` equals that value times 2^24 from the next cycle on.
- R3: Register 8+i holds the start of rank i in bits [7:0] and its end in bits [15:8], both in 64 MiB units. A DRAM address D selects rank i when start <= D[35:26] < end. The returned address is D minus start times 2^26, and the region code is 0 (DRAM).
- R4: A rank whose end value is 0 is never selected.
- R5: When several ranks match, the lowest index wins.
- R6: With remapping enabled, an address below 4 GiB whose bits [35:26] are at or above the aligned top of low memory returns region 2 (hole), with rank 0 and address 0.
- R7: Register 0 is the control word: bit 0 is the enable, bits [11:2] are the window base and bits [23:14] are the window limit, all in 64 MiB units. With the enable set and base <= A[35:26] < limit, the DRAM address is (top of low memory, aligned) + (A - base times 2^26). That DRAM address is then rank-decoded, and the region code is 1 (remapped).
- R8: With the enable clear, the window and the hole are ignored, and addresses decode only against the top of RAM and the ranks.
- R9: An address outside the window and at or above the top of RAM returns region 3 (miss), with rank 0 and address 0. So does a DRAM address that matches no rank.
- R10: Register 1 holds the top of low memory in MiB in bits [15:4]. Bits [3:0] are ignored, and the value is aligned down to 64 MiB (only bits [15:10] count).
- R11: Accepting a request gives a response exactly one cycle later. `req_ready` = !rsp_valid || rsp_ready. A response that is not taken stays unchanged.
- R12: A request accepted in the same cycle as a register write decodes with the configuration from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index |
| cfg_wdata | input | 24 | Register write data |
| top_of_ram | output | 36 | Top of RAM as a byte address |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_addr | input | 36 | Host physical address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rank | output | 3 | Selected rank index |
| rsp_addr | output | 36 | Rank-relative DRAM address |
| rsp_region | output | 2 | 0 DRAM, 1 remapped, 2 hole, 3 miss |

## Verification
A register write and a request acceptance can fall on the same clock edge. In that case the decode has to use the configuration from before the write. The bench drains the pipe, then drives a control-word write that clears the enable in the very cycle a request in the PCI hole is offered. It expects a hole response for that request and a DRAM response for the identical request that follows. The scoreboard model takes its configuration snapshot before it applies the write.

// File: rtl/remap_pkg.sv
package remap_pkg;
  typedef enum logic [1:0] {
    RGN_DRAM  = 2'd0,
    RGN_REMAP = 2'd1,
    RGN_HOLE  = 2'd2,
    RGN_MISS  = 2'd3
  } region_e;

  localparam int GRAN_SHIFT = 26;  // 64 MiB units
  localparam int TOR_SHIFT  = 24;  // 16 MiB units
  localparam int BOUND_W    = 8;   // per-rank boundary width
  localparam int TOR_W      = 11;
  localparam int TOLM_W     = 6;   // MiB count aligned to 64 MiB
  localparam int CFG_DW     = 24;
endpackage

// File: rtl/remap_cfg_regs.sv
module remap_cfg_regs
  import remap_pkg::*;
#(
  parameter int ADDR_W    = 36,
  parameter int NUM_RANKS = 8,
  localparam int BND_W    = ADDR_W - GRAN_SHIFT,
  localparam int CFG_AW   = $clog2(NUM_RANKS) + 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_we,
  input  logic [CFG_AW-1:0]                 cfg_addr,
  input  logic [CFG_DW-1:0]                 cfg_wdata,
  output logic                              remap_en,
  output logic [BND_W-1:0]                  win_base,
  output logic [BND_W-1:0]                  win_limit,
  output logic [TOLM_W-1:0]                 tolm_blk,
  output logic [ADDR_W-1:0]                 tor_addr,
  output logic [NUM_RANKS-1:0][BOUND_W-1:0] rank_lo,
  output logic [NUM_RANKS-1:0][BOUND_W-1:0] rank_hi
);
  localparam logic [CFG_AW-1:0] A_CTRL = CFG_AW'(0);
  localparam logic [CFG_AW-1:0] A_TOLM = CFG_AW'(1);
  localparam logic [CFG_AW-1:0] A_TOR  = CFG_AW'(2);

  logic ce_ctrl, ce_tolm, ce_tor;
  logic [TOR_W-1:0] tor_q;

  always_comb begin
    ce_ctrl = cfg_we && (cfg_addr == A_CTRL);
    ce_tolm = cfg_we && (cfg_addr == A_TOLM);
    ce_tor  = cfg_we && (cfg_addr == A_TOR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remap_en  <= 1'b0;
      win_base  <= '0;
      win_limit <= '0;
    end else if (ce_ctrl) begin
      remap_en  <= cfg_wdata[0];
      win_base  <= cfg_wdata[2 +: BND_W];
      win_limit <= cfg_wdata[14 +: BND_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tolm_blk <= '0;
    else if (ce_tolm) tolm_blk <= cfg_wdata[15:10];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tor_q <= '0;
    else if (ce_tor) tor_q <= cfg_wdata[TOR_W-1:0];
  end

  assign tor_addr = ADDR_W'({tor_q, {TOR_SHIFT{1'b0}}});

  for (genvar i = 0; i < NUM_RANKS; i++) begin : g_rank_reg
    logic ce_rank;
    assign ce_rank = cfg_we && (cfg_addr == CFG_AW'(NUM_RANKS + i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rank_lo[i] <= '0;
        rank_hi[i] <= '0;
      end else if (ce_rank) begin
        rank_lo[i] <= cfg_wdata[7:0];
        rank_hi[i] <= cfg_wdata[15:8];
      end
    end
  end

  // R2: top of RAM follows the written field one cycle later
  a_r2_tor_load: assert property (@(posedge clk) disable iff (!rst_n)
    ce_tor |=> tor_addr == ADDR_W'({$past(cfg_wdata[TOR_W-1:0]), {TOR_SHIFT{1'b0}}}));
endmodule

// File: rtl/remap_window.sv
module remap_window
  import remap_pkg::*;
#(
  parameter int ADDR_W   = 36,
  localparam int BND_W   = ADDR_W - GRAN_SHIFT,
  localparam int LOW4G_BIT = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              remap_en,
  input  logic [BND_W-1:0]  win_base,
  input  logic [BND_W-1:0]  win_limit,
  input  logic [TOLM_W-1:0] tolm_blk,
  input  logic [ADDR_W-1:0] tor_addr,
  output region_e           kind,
  output logic [ADDR_W-1:0] dram_addr
);
  logic [BND_W-1:0] blk, tolm_ext;
  logic in_win, in_hole, below_4g;

  always_comb begin
    blk      = addr[ADDR_W-1:GRAN_SHIFT];
    tolm_ext = BND_W'(tolm_blk);
    below_4g = (addr[ADDR_W-1:LOW4G_BIT] == '0);
    in_win   = remap_en && (blk >= win_base) && (blk < win_limit);
    in_hole  = remap_en && below_4g && (blk >= tolm_ext);
    dram_addr = addr;
    if (in_win) begin
      kind      = RGN_REMAP;
      dram_addr = {tolm_ext, {GRAN_SHIFT{1'b0}}}
                + (addr - {win_base, {GRAN_SHIFT{1'b0}}});
    end else if (in_hole) begin
      kind = RGN_HOLE;
    end else if (addr >= tor_addr) begin
      kind = RGN_MISS;
    end else begin
      kind = RGN_DRAM;
    end
  end
endmodule

// File: rtl/remap_rank_match.sv
module remap_rank_match
  import remap_pkg::*;
#(
  parameter int BND_W     = 10,
  parameter int NUM_RANKS = 8,
  localparam int RIDX_W   = $clog2(NUM_RANKS)
) (
  input  logic [BND_W-1:0]                  blk,
  input  logic [NUM_RANKS-1:0][BOUND_W-1:0] rank_lo,
  input  logic [NUM_RANKS-1:0][BOUND_W-1:0] rank_hi,
  output logic                              hit,
  output logic [RIDX_W-1:0]                 idx
);
  logic [NUM_RANKS-1:0] in_rng;

  for (genvar i = 0; i < NUM_RANKS; i++) begin : g_cmp
    assign in_rng[i] = (rank_hi[i] != '0)
                    && (BND_W'(rank_lo[i]) <= blk)
                    && (blk < BND_W'(rank_hi[i]));
  end

  always_comb begin
    hit = |in_rng;
    idx = '0;
    for (int i = NUM_RANKS - 1; i >= 0; i--) begin
      if (in_rng[i]) idx = RIDX_W'(i);
    end
  end
endmodule

// File: rtl/dram_remap_decoder.sv
module dram_remap_decoder
  import remap_pkg::*;
#(
  parameter int ADDR_W    = 36,
  parameter int NUM_RANKS = 8,
  localparam int RIDX_W   = $clog2(NUM_RANKS),
  localparam int CFG_AW   = RIDX_W + 1,
  localparam int BND_W    = ADDR_W - GRAN_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] top_of_ram,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [RIDX_W-1:0] rsp_rank,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [1:0]        rsp_region
);
  logic                              remap_en;
  logic [BND_W-1:0]                  win_base, win_limit;
  logic [TOLM_W-1:0]                 tolm_blk;
  logic [NUM_RANKS-1:0][BOUND_W-1:0] rank_lo, rank_hi;
  region_e                           kind, region_d;
  logic [ADDR_W-1:0]                 dram_addr, addr_d;
  logic                              hit;
  logic [RIDX_W-1:0]                 idx, rank_d;
  logic                              accept, valid_d;

  remap_cfg_regs #(.ADDR_W(ADDR_W), .NUM_RANKS(NUM_RANKS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .remap_en(remap_en), .win_base(win_base),
    .win_limit(win_limit), .tolm_blk(tolm_blk), .tor_addr(top_of_ram),
    .rank_lo(rank_lo), .rank_hi(rank_hi)
  );

  remap_window #(.ADDR_W(ADDR_W)) u_win (
    .addr(req_addr), .remap_en(remap_en), .win_base(win_base),
    .win_limit(win_limit), .tolm_blk(tolm_blk), .tor_addr(top_of_ram),
    .kind(kind), .dram_addr(dram_addr)
  );

  remap_rank_match #(.BND_W(BND_W), .NUM_RANKS(NUM_RANKS)) u_rank (
    .blk(dram_addr[ADDR_W-1:GRAN_SHIFT]), .rank_lo(rank_lo),
    .rank_hi(rank_hi), .hit(hit), .idx(idx)
  );

  // next-state
  always_comb begin
    region_d = kind;
    rank_d   = '0;
    addr_d   = '0;
    if (kind == RGN_DRAM || kind == RGN_REMAP) begin
      if (hit) begin
        rank_d = idx;
        addr_d = dram_addr - {BND_W'(rank_lo[idx]), {GRAN_SHIFT{1'b0}}};
      end else begin
        region_d = RGN_MISS;
      end
    end
    req_ready = !rsp_valid || rsp_ready;
    accept    = req_valid && req_ready;
    valid_d   = accept || (rsp_valid && !rsp_ready);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rank   <= '0;
      rsp_addr   <= '0;
      rsp_region <= '0;
    end else if (accept) begin
      rsp_rank   <= rank_d;
      rsp_addr   <= addr_d;
      rsp_region <= region_d;
    end
  end

  // R11: a stalled response holds every field
  a_r11_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_addr) && $stable(rsp_rank) && $stable(rsp_region)));

  // R11: one cycle from acceptance to response
  a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R6 / R9: non-DRAM responses carry zero rank and address
  a_r6_nondram_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_region[1]) |-> (rsp_addr == '0 && rsp_rank == '0));

  // R4: a selected rank never has a zero end boundary
  a_r4_rank_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid && req_ready) && !$past(cfg_we) && rsp_valid && !rsp_region[1])
      |-> rank_hi[rsp_rank] != '0);
endmodule

// File: tb/test_dram_remap_decoder.sv
`timescale 1ns/1ps
module test_dram_remap_decoder;
  localparam int AW = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_addr = '0;
  logic [23:0]   cfg_wdata = '0;
  logic [AW-1:0] top_of_ram;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [2:0]    rsp_rank;
  logic [AW-1:0] rsp_addr;
  logic [1:0]    rsp_region;

  always #4 clk = ~clk;  // 125 MHz

  dram_remap_decoder i_dram_remap_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .top_of_ram(top_of_ram), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rank(rsp_rank), .rsp_addr(rsp_addr),
    .rsp_region(rsp_region)
  );

  typedef struct packed {
    logic [2:0]    rank;
    logic [AW-1:0] addr;
    logic [1:0]    region;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  int    n_vec = 0;
  int    n_bad = 0;
  bit    stall_en = 0;

  // bench copy of the configuration, per the requirements
  bit         m_en;
  logic [9:0] m_base, m_limit;
  logic [5:0] m_tolm;
  logic [10:0] m_tor;
  logic [7:0] m_lo [8];
  logic [7:0] m_hi [8];

  function automatic exp_t model(logic [AW-1:0] a);
    exp_t e;
    logic [9:0] blk = a[35:26];
    logic [AW-1:0] d = a;
    logic [AW-1:0] tor = {1'b0, m_tor, 24'b0};
    bit remap = 0;
    bit found = 0;
    e = '0;
    if (m_en && blk >= m_base && blk < m_limit) begin
      remap = 1;
      d = {4'b0, m_tolm, 26'b0} + (a - {m_base, 26'b0});
    end else if (m_en && a < 36'h100000000 && blk >= {4'b0, m_tolm}) begin
      e.region = 2'd2;
      return e;
    end else if (a >= tor) begin
      e.region = 2'd3;
      return e;
    end
    for (int i = 0; i < 8; i++) begin
      if (!found && m_hi[i] != 0 && {2'b0, m_lo[i]} <= d[35:26]
          && d[35:26] < {2'b0, m_hi[i]}) begin
        found = 1;
        e.rank = 3'(i);
        e.addr = d - {2'b0, m_lo[i], 26'b0};
        e.region = remap ? 2'd1 : 2'd0;
      end
    end
    if (!found) e.region = 2'd3;
    return e;
  endfunction

  function automatic void mirror(logic [3:0] ra, logic [23:0] wd);
    if (ra == 4'd0) begin
      m_en = wd[0]; m_base = wd[11:2]; m_limit = wd[23:14];
    end else if (ra == 4'd1) begin
      m_tolm = wd[15:10];
    end else if (ra == 4'd2) begin
      m_tor = wd[10:0];
    end else if (ra >= 4'd8) begin
      m_lo[ra - 8] = wd[7:0]; m_hi[ra - 8] = wd[15:8];
    end
  endfunction

  task automatic wr(logic [3:0] ra, logic [23:0] wd);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = ra; cfg_wdata = wd;
    @(negedge clk);
    cfg_we = 1'b0;
    mirror(ra, wd);
  endtask

  task automatic send(logic [AW-1:0] a, string tag);
    bit acc;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    do begin
      #1;
      acc = req_ready;
      if (acc) begin
        expq.push_back(model(a));
        tagq.push_back(tag);
      end
      @(negedge clk);
    end while (!acc);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check(bit ok, string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares each handshaken response against the queue
  initial begin
    forever begin
      @(negedge clk);
      rsp_ready = stall_en ? ($urandom_range(0, 2) != 0) : 1'b1;
      #2;
      if (rst_n && rsp_valid && rsp_ready) begin
        exp_t e;
        string t;
        if (expq.size() == 0) begin
          check(0, "R11 unexpected response", {34'b0, rsp_region}, '0);
        end else begin
          e = expq.pop_front();
          t = tagq.pop_front();
          check(rsp_region == e.region, {t, " region"}, AW'(rsp_region), AW'(e.region));
          check(rsp_rank == e.rank, {t, " rank"}, AW'(rsp_rank), AW'(e.rank));
          check(rsp_addr == e.addr, {t, " addr"}, rsp_addr, e.addr);
        end
      end
    end
  end

  initial begin
    #1500000;
    n_vec++; n_bad++;
    $display("FAIL watchdog expired actual=hang expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    m_en = 0; m_base = '0; m_limit = '0; m_tolm = '0; m_tor = '0;
    for (int i = 0; i < 8; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R1 rsp_valid", AW'(rsp_valid), '0);
    check(req_ready == 1'b1, "R1 req_ready", AW'(req_ready), AW'(1));
    check(top_of_ram == '0, "R1 top_of_ram", top_of_ram, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // top of RAM 5 GiB = 320 x 16 MiB
    wr(4'd2, 24'd320);
    #1 check(top_of_ram == 36'h140000000, "R2 top_of_ram", top_of_ram, 36'h140000000);
    // ranks: 0:[0,1G) 1:[1G,3G) 2:[3G,5G) 3 empty 5 overlaps rank 1
    wr(4'd8,  {8'd16, 8'd0});
    wr(4'd9,  {8'd48, 8'd16});
    wr(4'd10, {8'd80, 8'd48});
    wr(4'd11, {8'd0,  8'd0});
    wr(4'd13, {8'd30, 8'd20});
    // top of low memory 3100 MiB with junk in bits [3:0]: aligns to 3 GiB
    wr(4'd1, 24'hC1CF);
    // window [5G,6G), enable clear
    wr(4'd0, 24'd96 << 14 | 24'd80 << 2);

    send(36'h0E0000000, "R8 hole ignored when disabled");
    send(36'h160000000, "R8 window ignored when disabled");
    send(36'h140000000, "R9 at top of RAM");
    send(36'h000000100, "R3 rank0 low");
    send(36'h040000000, "R3 end bound half-open");
    send(36'h050000000, "R5 overlap lowest index");

    wr(4'd0, 24'd96 << 14 | 24'd80 << 2 | 24'd1);
    stall_en = 1;
    send(36'h0E0000000, "R6 hole");
    send(36'h0BFE00000, "R10 below aligned tolm");
    send(36'h0C0000000, "R10 aligned tolm is hole");
    send(36'h160000000, "R7 remap mid");
    send(36'h140000000, "R7 remap base");
    send(36'h180000000, "R9 at window limit");
    send(36'h120000000, "R3 direct above 4G");
    send(36'h1A0000000, "R9 beyond window");
    send(36'h0B8000000, "R3 rank1");
    for (int k = 0; k < 24; k++)
      send(AW'(k) * 36'h10000000 + 36'h123440, "R11 sweep under stall");
    drain();
    stall_en = 0;
    drain();

    // R12: write clearing enable in the same cycle as a hole request
    @(negedge clk);
    req_valid = 1'b1; req_addr = 36'h0E0000000;
    cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = 24'd96 << 14 | 24'd80 << 2;
    #1;
    check(req_ready == 1'b1, "R12 ready", AW'(req_ready), AW'(1));
    expq.push_back(model(36'h0E0000000));
    tagq.push_back("R12 old config used");
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    mirror(4'd0, 24'd96 << 14 | 24'd80 << 2);
    send(36'h0E0000000, "R12 new config used");

    // R4: emptying rank 2 leaves 3.5G without a rank
    wr(4'd10, {8'd0, 8'd48});
    send(36'h0E0000000, "R4 empty rank never selected");
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule